// File: doc/BRIEF.md
# Branch Linkage and Addressing-Mode Unit

This unit is the control-transfer slice of a CPU core that runs in two addressing modes, 24-bit and 31-bit. It holds the mode bit of the status word. For each decoded call, return or sequential step it produces four results: the next instruction address, the next mode, and a link-register value with its write enable. All four results come from the current instruction address, the instruction length code, the condition code, the program mask, the link register contents and the branch target register contents.

It also masks an effective address combinationally, according to the mode currently in force. Two of the operations switch the addressing mode as part of the same transfer. Together they cover every combination of caller and callee: 24 to 31, 31 to 24, 24 to 24 and 31 to 31.

Top module: `brlink_unit`

Operation codes on `op` are:

| Code | Operation |
|------|-----------|
| 0 | sequential step |
| 1 | legacy link |
| 2 | save |
| 3 | save-and-set-mode |
| 4 | set-mode |
| 5 to 7 | behave as code 0 |

Mode encoding:

- In the `mode` output and in bit 31 of a target or link word, 1 means 31-bit mode and 0 means 24-bit mode.
- The return address is `instr_addr + 2*ilc`, masked in the mode in force before the operation.

## Requirements
- R1: `ea_out` equals `ea_in` with bits 31:24 cleared while `mode` is 0, and with only bit 31 cleared while `mode` is 1.
- R2: The sequential step (op 0, and ops 5 to 7) sets `next_addr` to the masked return address, leaves `mode` unchanged and does not write the link register.
- R3: Legacy link writes `{ilc[1:0], cc[1:0], pmask[3:0], ret[23:0]}` in 24-bit mode, with the status byte at bits 31:30, 29:28 and 27:24. In 31-bit mode it writes `{1'b1, ret[30:0]}`.
- R4: Save writes `{8'h00, ret[23:0]}` in 24-bit mode and `{1'b0, ret[30:0]}` in 31-bit mode.
- R5: Save-and-set-mode writes `{old_mode, ret[30:0]}` to the link register, where ret is masked in the old mode.
- R6: When a branch is taken, save-and-set-mode and set-mode set the mode to `tgt_in[31]` and `next_addr` to `tgt_in` masked in that new mode. This holds for all four caller/callee mode pairs.
- R7: Set-mode writes `{old_mode, link_in[30:0]}` when `link_none` is 0. It performs no link write when `link_none` is 1.
- R8: When `tgt_none` is 1, no branch is taken. `next_addr` is the return address and the mode is unchanged, but the link write defined by the operation still happens.
- R9: When a branch is taken, legacy link and save set `next_addr` to `tgt_in` masked in the current mode and leave the mode unchanged.
- R10: All results appear together on the clock edge that samples `op_valid` high. `link_we` is high for exactly that one cycle. Outputs hold while `op_valid` is low.
- R11: After reset, `mode` is 0 (24-bit), `next_addr` is 0 and `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code |
| instr_addr | input | 32 | Address of the current instruction |
| ilc | input | 2 | Instruction length in halfwords |
| cc | input | 2 | Condition code |
| pmask | input | 4 | Program mask |
| link_in | input | 32 | Current contents of the link register |
| tgt_in | input | 32 | Contents of the target register |
| tgt_none | input | 1 | Target register field is 0 (no branch) |
| link_none | input | 1 | Link register field is 0 (set-mode only) |
| ea_in | input | 32 | Effective address to be masked |
| ea_out | output | 32 | Effective address masked in the current mode |
| next_addr | output | 32 | Next instruction address |
| mode | output | 1 | Addressing mode, 1 = 31-bit |
| link_we | output | 1 | Link register write enable |
| link_wdata | output | 32 | Link register write value |

## Verification
A corrupted mode bit shows at `ea_out` in the very next cycle, because the masking of bits 30:24 flips at once. It also shows in every later link word and branch target. A wrong return address or status byte shows in `link_wdata` on the single cycle of `link_we`. A mode or address that switched out of step shows as a `next_addr`/`mode` pair that disagrees on the same edge. The bench compares every output against its model on every clock, so any of these faults is reported within one cycle.

// File: rtl/brlink_unit.sv
module brlink_unit #(
  parameter bit RESET_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op,
  input  logic [31:0] instr_addr,
  input  logic [1:0]  ilc,
  input  logic [1:0]  cc,
  input  logic [3:0]  pmask,
  input  logic [31:0] link_in,
  input  logic [31:0] tgt_in,
  input  logic        tgt_none,
  input  logic        link_none,
  input  logic [31:0] ea_in,
  output logic [31:0] ea_out,
  output logic [31:0] next_addr,
  output logic        mode,
  output logic        link_we,
  output logic [31:0] link_wdata
);
  localparam logic [31:0] MASK24 = 32'h00FF_FFFF;
  localparam logic [31:0] MASK31 = 32'h7FFF_FFFF;
  localparam logic [2:0]  OP_LINK = 3'd1, OP_SAVE = 3'd2, OP_SAVESET = 3'd3, OP_SETMODE = 3'd4;

  function automatic logic [31:0] amask(input logic [31:0] a, input logic m);
    return a & (m ? MASK31 : MASK24);
  endfunction

  logic [31:0] ret, n_addr, n_wd;
  logic        n_mode, n_we, branch, set_mode;

  assign ea_out = amask(ea_in, mode);
  assign ret    = amask(instr_addr + {29'd0, ilc, 1'b0}, mode);
  assign branch = !tgt_none && (op == OP_LINK || op == OP_SAVE || op == OP_SAVESET || op == OP_SETMODE);
  assign set_mode = op == OP_SAVESET || op == OP_SETMODE;

  always_comb begin
    n_we = 1'b0;
    n_wd = link_wdata;
    case (op)
      OP_LINK: begin
        n_we = 1'b1;
        n_wd = mode ? {1'b1, ret[30:0]} : {ilc, cc, pmask, ret[23:0]};
      end
      OP_SAVE: begin
        n_we = 1'b1;
        n_wd = ret;
      end
      OP_SAVESET: begin
        n_we = 1'b1;
        n_wd = {mode, ret[30:0]};
      end
      OP_SETMODE: begin
        n_we = !link_none;
        n_wd = link_none ? link_wdata : {mode, link_in[30:0]};
      end
      default: ;
    endcase
    n_mode = (branch && set_mode) ? tgt_in[31] : mode;
    n_addr = branch ? amask(tgt_in, n_mode) : ret;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= RESET_MODE;
      next_addr  <= '0;
      link_we    <= 1'b0;
      link_wdata <= '0;
    end else if (op_valid) begin
      mode       <= n_mode;
      next_addr  <= n_addr;
      link_we    <= n_we;
      link_wdata <= n_wd;
    end else begin
      link_we <= 1'b0;
    end
  end
endmodule

// File: rtl/brlink_unit_chk.sv
module brlink_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op,
  input logic [1:0]  ilc,
  input logic [1:0]  cc,
  input logic [3:0]  pmask,
  input logic [31:0] tgt_in,
  input logic        tgt_none,
  input logic        link_none,
  input logic [31:0] ea_out,
  input logic [31:0] next_addr,
  input logic        mode,
  input logic        link_we,
  input logic [31:0] link_wdata
);
  p_ea_top_r1: assert property (@(posedge clk) disable iff (!rst_n) ea_out[31] == 1'b0);
  p_ea24_r1: assert property (@(posedge clk) disable iff (!rst_n) !mode |-> ea_out[31:24] == 8'h00);
  p_seq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 3'd0 || op > 3'd4) |=> !link_we && $stable(mode));
  p_link_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 3'd1 && !mode |=> link_we && link_wdata[31:24] == {$past(ilc), $past(cc), $past(pmask)});
  p_save_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 3'd2 |=> link_we && link_wdata[31] == 1'b0);
  p_saveset_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 3'd3 |=> link_we && link_wdata[31] == $past(mode));
  p_new_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 3'd3 || op == 3'd4) && !tgt_none |=> mode == $past(tgt_in[31]));
  p_next24_r6: assert property (@(posedge clk) disable iff (!rst_n) !mode |-> next_addr[31:24] == 8'h00);
  p_nolink_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 3'd4 && link_none |=> !link_we);
  p_nobranch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && tgt_none |=> $stable(mode));
  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !link_we && $stable(mode) && $stable(next_addr));
endmodule

bind brlink_unit brlink_unit_chk u_chk (.*);

// File: tb/sim_brlink_unit.sv
module sim_brlink_unit;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, tgt_none = 1'b0, link_none = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] instr_addr = '0, link_in = '0, tgt_in = '0, ea_in = '0;
  logic [1:0] ilc = '0, cc = '0;
  logic [3:0] pmask = '0;
  logic [31:0] ea_out, next_addr, link_wdata;
  logic mode, link_we;
  int errors = 0, checks = 0;

  // reference state
  bit m_mode = 0, m_we = 0;
  bit [31:0] m_addr = 0, m_wd = 0;

  always #5 clk = ~clk;

  brlink_unit u0 (.*);

  function automatic bit [31:0] msk(bit [31:0] a, bit m);
    if (m) return a & 32'h7FFF_FFFF;
    return a & 32'h00FF_FFFF;
  endfunction

  task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, {31'd0, mode}, {31'd0, m_mode});
    chk(req, next_addr, m_addr);
    chk(req, {31'd0, link_we}, {31'd0, m_we});
    if (m_we) chk(req, link_wdata, m_wd);
    chk("R1", ea_out, msk(ea_in, m_mode));
  endtask

  task automatic step(string req, bit v, bit [2:0] o, bit [31:0] ia, bit [1:0] l,
                      bit [31:0] tg, bit tn, bit [31:0] lk, bit ln);
    bit [31:0] ret;
    bit br, sm;
    @(negedge clk);
    op_valid = v; op = o; instr_addr = ia; ilc = l; tgt_in = tg; tgt_none = tn;
    link_in = lk; link_none = ln; cc = 2'b10; pmask = 4'hB;
    ea_in = ea_in ^ 32'hA5C3_7E19 ^ ia;
    ret = msk(ia + 2 * l, m_mode);
    br = !tn && o >= 1 && o <= 4;
    sm = o == 3 || o == 4;
    @(posedge clk);
    if (v) begin
      m_we = 0;
      case (o)
        1: begin m_we = 1; m_wd = m_mode ? {1'b1, ret[30:0]} : {ilc, cc, pmask, ret[23:0]}; end
        2: begin m_we = 1; m_wd = m_mode ? {1'b0, ret[30:0]} : {8'h00, ret[23:0]}; end
        3: begin m_we = 1; m_wd = {m_mode, ret[30:0]}; end
        4: if (!ln) begin m_we = 1; m_wd = {m_mode, lk[30:0]}; end
        default: ;
      endcase
      if (br && sm) m_mode = tg[31];
      m_addr = br ? msk(tg, m_mode) : ret;
    end else m_we = 0;
    #2;
    compare(req);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ea_in = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #2;
    compare("R11");
    @(negedge clk); rst_n = 1'b1;
    step("R2", 1, 0, 32'hFF12_3450, 2, 32'h0, 0, 0, 0);
    step("R2", 1, 6, 32'h0000_1000, 3, 32'hFFFF_FFFF, 0, 0, 0);
    step("R3", 1, 1, 32'hAB00_2000, 2, 32'hFF00_8000, 0, 0, 0);
    step("R4", 1, 2, 32'h0012_3456, 1, 32'h8000_4000, 0, 0, 0);
    step("R9", 1, 2, 32'h0000_0100, 2, 32'h0000_0000, 1, 0, 0);
    step("R6", 1, 3, 32'h00FF_FFFE, 1, 32'hC123_4568, 0, 0, 0);    // 24 -> 31
    step("R3", 1, 1, 32'h4000_0000, 2, 32'hF000_0000, 0, 0, 0);
    step("R4", 1, 2, 32'h7FFF_FFFC, 2, 32'h8111_1110, 0, 0, 0);
    step("R5", 1, 3, 32'h1234_5678, 2, 32'hBEEF_0000, 0, 0, 0);     // 31 -> 31
    step("R8", 1, 3, 32'h2000_0000, 1, 32'h0000_0000, 1, 0, 0);
    step("R10", 0, 3, 32'h0, 0, 32'h0, 0, 0, 0);
    step("R10", 0, 1, 32'h0, 0, 32'h0, 0, 0, 0);
    step("R6", 1, 3, 32'h3000_0000, 2, 32'h7A12_3456, 0, 0, 0);     // 31 -> 24
    step("R6", 1, 3, 32'h0000_0040, 2, 32'h7F00_0080, 0, 0, 0);     // 24 -> 24
    step("R7", 1, 4, 32'h0, 0, 32'h9000_0010, 0, 32'hFFFF_0000, 0); // 24 -> 31
    step("R7", 1, 4, 32'h0, 0, 32'h0055_0000, 0, 32'h1234_5678, 1); // 31 -> 24, no save
    step("R7", 1, 4, 32'h0, 0, 32'h0, 1, 32'h8765_4321, 0);
    step("R8", 1, 4, 32'h0010_0000, 2, 32'h8000_0000, 1, 0, 1);
    step("R6", 1, 4, 32'h0, 0, 32'hFFFF_FFFF, 0, 0, 1);             // 24 -> 31
    step("R6", 1, 4, 32'h0, 0, 32'hFFFF_FFFF, 0, 32'h1, 0);         // 31 -> 31
    step("R9", 1, 1, 32'h5000_0000, 1, 32'h0ABC_DEF0, 0, 0, 0);
    for (int i = 0; i < 40; i++)
      step("R1", 1, 3'(i % 6), 32'h0137_9BDF * i, 2'(i), {i[0], 31'h2468_ACE0} ^ (i << 20),
           i % 7 == 0, 32'hCAFE_0000 + i, i[1]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule